// File: doc/BRIEF.md
# Crosswise Column Multiplier with 4:2 Compressors

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. Every operand bit pair whose indices add up to k carries weight 2^k, so the product is assembled by weight column rather than by shifting and adding whole rows. Each column's equal-weight bits are fed into 4:2 compressor cells. Those cells hand their carries to the next-higher column. The matrix shrinks level by level until only two bits remain per column, and a final carry-propagate adder resolves those two rows into the result.

By default the block is purely combinational, so the product follows the operands in the same cycle. A parameter places one register on the output. That register has an asynchronous active-low reset and gives a fixed latency of one clock. The operand width is a parameter, but it must be a power of two no smaller than four. The default is 8.

Top module: `vcm_mult`

## Requirements
- R1: With OUT_REG=0, `prod` equals the unsigned product `op_x * op_y` in the same cycle, for all 65536 operand pairs.
- R2: When either operand is zero, `prod` is 16'h0000.
- R3: Each 4:2 compressor cell keeps the arithmetic weight of its inputs: x1+x2+x3+x4+cin = sum + 2*(carry+cout). Its cout does not depend on its cin, so the columns of a compressor row hold their full-height sums for every operand pair.
- R4: Carries that leave the top column are discarded without corrupting the result. The full-scale product 255*255 is 16'hFE01, and 128*128 is 16'h4000.
- R5: An operand of one passes the other operand through unchanged, zero-extended to 16 bits.
- R6: With OUT_REG=1, `prod` shows the product of the operands sampled at the previous rising edge of `clk`.
- R7: With OUT_REG=1, driving `rst_n` low clears `prod` to 16'h0000 at once, without waiting for a clock edge, and it stays at zero while `rst_n` is low.
- R8: Alternating-bit operands give exact products: 0xAA*0x55 = 16'h3872, 0xAA*0xAA = 16'h70E4, and 0x55*0x55 = 16'h1C39.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_x | input | 8 | Multiplicand, unsigned, bit 0 is the LSB |
| op_y | input | 8 | Multiplier, unsigned, bit 0 is the LSB |
| prod | output | 16 | Unsigned product |

## Verification
Several corner cases are targeted directly:
- **Tallest columns.** All-ones operands fill every column to its maximum height and push carries out of the top column. A compressor row that dropped or double-counted a carry would give a wrong 255*255 result, and discarding the top carry at the wrong place would wrap the product.
- **Sparse operands.** Zero, one and alternating-bit patterns leave most columns sparse. A misrouted partial-product bit shows up there as a single flipped product bit.
- **Full sweep.** Every one of the 65536 operand pairs is compared with an arithmetic product, so no column path can hide behind a lucky pattern.

The registered variant is checked for an output that is off by one cycle. It is also checked for an output that stays nonzero after an asynchronous reset is asserted between clock edges.

// File: rtl/vcm_pkg.sv
`timescale 1ns/1ps
package vcm_pkg;

    // Index of the first row of a reduction level in the flattened row store.
    // Level 0 holds W rows; each later level holds half as many.
    function automatic int level_base(input int w, input int lv);
        return 2 * w - 2 * (w >> lv);
    endfunction

    // Number of 4:2 levels needed to bring W rows down to two.
    function automatic int tree_levels(input int w);
        int n;
        int r;
        n = 0;
        r = w;
        while (r > 2) begin
            r = r / 2;
            n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/vcm_fa.sv
`timescale 1ns/1ps
module vcm_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/vcm_comp42.sv
`timescale 1ns/1ps
module vcm_comp42 (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic s_mid;

    // The first stage sees only x1..x3, so cout never waits for cin.
    vcm_fa u_fa_first (
        .a (x1),
        .b (x2),
        .ci(x3),
        .s (s_mid),
        .co(cout)
    );

    vcm_fa u_fa_second (
        .a (s_mid),
        .b (x4),
        .ci(cin),
        .s (sum),
        .co(carry)
    );

    always_comb begin
        if (!$isunknown({x1, x2, x3, x4, cin, sum, carry, cout})) begin
            // R3
            weight_kept_chk: assert (int'(x1) + int'(x2) + int'(x3) + int'(x4) + int'(cin)
                                     == int'(sum) + 2 * (int'(carry) + int'(cout)));
        end
    end
endmodule

// File: rtl/vcm_ppgen.sv
`timescale 1ns/1ps
module vcm_ppgen #(
    parameter int W = 8
) (
    input  logic [W-1:0]                x,
    input  logic [W-1:0]                y,
    output logic [W-1:0][2*W-1:0]       pp
);
    localparam int PW = 2 * W;

    // Row j holds every pair X[i]&Y[j], placed at weight i+j.
    for (genvar j = 0; j < W; j++) begin : g_row
        logic [PW-1:0] row_w;
        assign row_w = {{W{1'b0}}, x & {W{y[j]}}} << j;
        assign pp[j] = row_w;
    end
endmodule

// File: rtl/vcm_row42.sv
`timescale 1ns/1ps
module vcm_row42 #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] a,
    input  logic [PW-1:0] b,
    input  logic [PW-1:0] c,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] s,
    output logic [PW-1:0] cy
);
    logic [PW:0]   link;
    logic [PW-1:0] carry_w;
    logic          unused_top;

    assign link[0] = 1'b0;

    // One compressor per weight column; cout feeds the next column's cin.
    for (genvar k = 0; k < PW; k++) begin : g_col
        vcm_comp42 u_cell (
            .x1   (a[k]),
            .x2   (b[k]),
            .x3   (c[k]),
            .x4   (d[k]),
            .cin  (link[k]),
            .sum  (s[k]),
            .carry(carry_w[k]),
            .cout (link[k+1])
        );
    end

    // Carries move one column up; those leaving the top column are dropped.
    assign cy         = {carry_w[PW-2:0], 1'b0};
    assign unused_top = carry_w[PW-1] ^ link[PW];

    logic [PW-1:0] in_total;
    logic [PW-1:0] out_total;
    assign in_total  = a + b + c + d;
    assign out_total = s + cy;

    always_comb begin
        if (!$isunknown({a, b, c, d, s, cy})) begin
            // R3
            row_sum_kept_chk: assert (in_total == out_total);
        end
    end
endmodule

// File: rtl/vcm_cpa.sv
`timescale 1ns/1ps
module vcm_cpa #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] a,
    input  logic [PW-1:0] b,
    output logic [PW-1:0] s
);
    logic [PW:0] rip;
    logic        unused_cout;

    assign rip[0] = 1'b0;

    for (genvar k = 0; k < PW; k++) begin : g_bit
        vcm_fa u_fa (
            .a (a[k]),
            .b (b[k]),
            .ci(rip[k]),
            .s (s[k]),
            .co(rip[k+1])
        );
    end

    assign unused_cout = rip[PW];

    logic [PW-1:0] ref_sum;
    assign ref_sum = a + b;

    always_comb begin
        if (!$isunknown({a, b, s})) begin
            // R4
            final_add_chk: assert (s == ref_sum);
        end
    end
endmodule

// File: rtl/vcm_mult.sv
`timescale 1ns/1ps
module vcm_mult
    import vcm_pkg::*;
#(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     op_x,
    input  logic [W-1:0]     op_y,
    output logic [2*W-1:0]   prod
);
    localparam int PW     = 2 * W;
    localparam int LEVELS = tree_levels(W);
    localparam int TOTAL  = 2 * W - 2;

    typedef struct packed {
        logic [PW-1:0] prod;
    } out_t;

    logic [TOTAL-1:0][PW-1:0] rows;
    logic [PW-1:0]            sum_w;
    out_t                     st_d;

    vcm_ppgen #(.W(W)) u_ppgen (
        .x (op_x),
        .y (op_y),
        .pp(rows[W-1:0])
    );

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int IN_B  = level_base(W, lv);
        localparam int OUT_B = level_base(W, lv + 1);
        localparam int NIN   = W >> lv;
        for (genvar g = 0; g < NIN / 4; g++) begin : g_grp
            vcm_row42 #(.PW(PW)) u_row (
                .a (rows[IN_B + 4*g]),
                .b (rows[IN_B + 4*g + 1]),
                .c (rows[IN_B + 4*g + 2]),
                .d (rows[IN_B + 4*g + 3]),
                .s (rows[OUT_B + 2*g]),
                .cy(rows[OUT_B + 2*g + 1])
            );
        end
    end

    vcm_cpa #(.PW(PW)) u_cpa (
        .a(rows[TOTAL-2]),
        .b(rows[TOTAL-1]),
        .s(sum_w)
    );

    always_comb begin
        st_d      = '0;
        st_d.prod = sum_w;
    end

    logic [PW-1:0] ref_prod;
    assign ref_prod = PW'(op_x) * PW'(op_y);

    if (OUT_REG) begin : g_reg
        out_t st_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign prod = st_q.prod;

        // R6
        latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> prod == $past(ref_prod));

        // R7
        reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> prod == '0);
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign prod       = st_d.prod;

        always_comb begin
            if (!$isunknown({op_x, op_y, prod})) begin
                // R1
                exact_product_chk: assert (prod == ref_prod);
                // R2
                zero_operand_chk: assert (!(op_x == '0 || op_y == '0) || prod == '0);
            end
        end
    end
endmodule

// File: tb/test_vcm_mult.sv
`timescale 1ns/1ps
module test_vcm_mult;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  x     = 8'hA5;
    logic [7:0]  y     = 8'h3C;
    logic [15:0] p_comb;
    logic [15:0] p_reg;
    logic [7:0]  prev_x = 8'hA5;
    logic [7:0]  prev_y = 8'h3C;
    int          errs   = 0;
    int          checks = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    vcm_mult #(.W(8), .OUT_REG(1'b0)) i_vcm_mult (
        .clk  (clk),
        .rst_n(rst_n),
        .op_x (x),
        .op_y (y),
        .prod (p_comb)
    );

    vcm_mult #(.W(8), .OUT_REG(1'b1)) i_vcm_mult_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .op_x (x),
        .op_y (y),
        .prod (p_reg)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: x=%h y=%h actual=%h expected=%h", req, x, y, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input string req);
        @(posedge clk);
        #1;
        x = a;
        y = b;
        @(negedge clk);
        chk(req, p_comb, 16'(a) * 16'(b));
        // R6: register shows the pair that was present at the edge just passed
        chk("R6", p_reg, 16'(prev_x) * 16'(prev_y));
        prev_x = a;
        prev_y = b;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset", p_reg, 16'h0000);
        chk("R1 during reset", p_comb, 16'(x) * 16'(y));
        rst_n = 1'b1;

        apply(8'h00, 8'h00, "R2");
        apply(8'h00, 8'hFF, "R2");
        apply(8'hFF, 8'h00, "R2");
        apply(8'h01, 8'hFF, "R5");
        apply(8'hFF, 8'h01, "R5");
        apply(8'h01, 8'h01, "R5");
        apply(8'hFF, 8'hFF, "R3 R4");
        chk("R4 full scale", p_comb, 16'hFE01);
        apply(8'h80, 8'h80, "R4");
        chk("R4 top bit", p_comb, 16'h4000);
        apply(8'hAA, 8'h55, "R8");
        chk("R8 const", p_comb, 16'h3872);
        apply(8'h55, 8'hAA, "R8");
        apply(8'hAA, 8'hAA, "R8");
        chk("R8 const", p_comb, 16'h70E4);
        apply(8'h55, 8'h55, "R8");
        chk("R8 const", p_comb, 16'h1C39);

        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b), "R1");
            end
        end

        // R7: asynchronous clear between clock edges
        @(posedge clk);
        #1;
        x = 8'hFF;
        y = 8'hFF;
        @(posedge clk);
        #1;
        chk("R6 before reset", p_reg, 16'hFE01);
        rst_n = 1'b0;
        #0.5;
        chk("R7 async", p_reg, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        chk("R7 held", p_reg, 16'h0000);
        rst_n  = 1'b1;
        prev_x = 8'hFF;
        prev_y = 8'hFF;
        apply(8'h12, 8'h34, "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule